// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with Clear-on-Match

A 16-bit up-counter advanced by a one-cycle enable pulse (`tick`) from an external prescaler. A small write port loads a control word, the counter itself, a compare value and a top/capture value. A 4-bit sequence code picks how the counter runs. It either free-runs and wraps at the maximum value, or it restarts from zero after reaching a top value. That top value is taken from the compare register or from the capture register. There is no read port: the count, the three event flags and the waveform pin are plain outputs.

A compare match drives one waveform pin. A 2-bit pin-action code chooses whether a match toggles, clears or sets the pin, or whether the pin is released. The pin-action code never alters the count sequence. There are three sticky event flags: overflow, compare match and top-of-capture. Each flag is cleared by its own acknowledge input or by writing a one to its bit at the flag-clear address.

There is no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `tmr16_ctc`

## Requirements
- R1: After reset the count is 0, the control word, compare and capture registers are 0, all three flags are 0, the waveform pin is 0 and its output enable is 0.
- R2: With sequence code 0 (free-running), every `tick` cycle adds one to the count and 0xFFFF wraps to 0x0000. The count is never cleared by a match.
- R3: The overflow flag is set on the same clock edge at which a tick carries the count from 0xFFFF to 0x0000, in every sequence code.
- R4: Flags are cleared only by their acknowledge input (`ack_ovf`, `ack_cmp`, `ack_cap`) or by a write to address 4 with bit 0 = overflow, bit 1 = compare, bit 2 = capture-top. When a set and a clear of one flag fall in the same cycle, the flag ends up set.
- R5: With sequence code 4, a tick taken while the count equals the compare register loads 0 into the count and sets the compare flag.
- R6: With sequence code 12, a tick taken while the count equals the capture register loads 0 into the count and sets the capture-top flag. A tick taken while the count equals the compare register still sets the compare flag and drives the pin.
- R7: The control word at address 0 holds the sequence code in bits [3:0] and the pin action in bits [5:4]. On a compare-match tick, action 1 toggles the pin, 2 drives it to 0 and 3 drives it to 1. With action 0 the output enable is 0 and the pin level holds. The output enable is 1 for any nonzero action, and the action never changes the count sequence.
- R8: A write to address 1 loads the count on the next edge and takes precedence over a tick in the same cycle. On the first tick after such a write, compare-match effects are suppressed: the compare flag, the pin action, the top clear and the capture-top flag.
- R9: Sequence codes other than 0, 4 and 12 count like code 0 and set flags like code 0, but the pin keeps its level.
- R10: Without a tick the count, the flags (apart from clears) and the pin do not change. The other register addresses are 2 = compare and 3 = capture/top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler count enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 count, 2 compare, 3 capture/top, 4 flag clear) |
| wr_data | input | 16 | Write data |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the compare flag |
| ack_cap | input | 1 | Clears the capture-top flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare match flag |
| cap_flag | output | 1 | Capture-top flag |
| wave_out | output | 1 | Waveform pin level |
| wave_oe | output | 1 | Waveform pin output enable |

## Verification
The assertions make no assumption about how far apart ticks are, and they allow a write and a tick in the same cycle. They do assume that `tick`, `wr_en` and the acknowledge inputs are driven to known levels from the first edge after reset. The bench drives every input on the falling edge and spaces ticks with idle cycles, so each count step can be seen alone. It deliberately overlaps a write and a tick, and a set and an acknowledge, only in the directed priority tests.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    SEQ_FREE    = 2'd0,
    SEQ_TOP_CMP = 2'd1,
    SEQ_TOP_CAP = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pin_act_e;

  localparam logic [3:0] CODE_FREE    = 4'd0;
  localparam logic [3:0] CODE_TOP_CMP = 4'd4;
  localparam logic [3:0] CODE_TOP_CAP = 4'd12;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CNT  = 1;
  localparam int unsigned ADDR_CMP  = 2;
  localparam int unsigned ADDR_CAP  = 3;
  localparam int unsigned ADDR_FCLR = 4;

  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_CMP = 1;
  localparam int unsigned FLAG_CAP = 2;

  function automatic seq_e seq_of(input logic [3:0] code);
    case (code)
      CODE_TOP_CMP: seq_of = SEQ_TOP_CMP;
      CODE_TOP_CAP: seq_of = SEQ_TOP_CAP;
      default:      seq_of = SEQ_FREE;
    endcase
  endfunction

  function automatic logic known_code(input logic [3:0] code);
    known_code = (code == CODE_FREE) || (code == CODE_TOP_CMP) || (code == CODE_TOP_CAP);
  endfunction

endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [W-1:0]                wr_data,
  output logic [3:0]                  seq_code,
  output logic [1:0]                  pin_act,
  output logic [W-1:0]                cmp_val,
  output logic [W-1:0]                cap_val,
  output logic                        cnt_load,
  output logic [tmr16_pkg::FLAG_N-1:0] fclr_mask
);
  import tmr16_pkg::*;

  logic [5:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_val <= '0;
      cap_val <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        ADDR_CTRL: ctrl_q  <= wr_data[5:0];
        ADDR_CMP:  cmp_val <= wr_data;
        ADDR_CAP:  cap_val <= wr_data;
        default: ;
      endcase
    end
  end

  assign seq_code  = ctrl_q[3:0];
  assign pin_act   = ctrl_q[5:4];
  assign cnt_load  = wr_en && (int'(wr_addr) == ADDR_CNT);
  assign fclr_mask = (wr_en && (int'(wr_addr) == ADDR_FCLR)) ? wr_data[FLAG_N-1:0] : '0;

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  tmr16_pkg::seq_e     seq,
  input  logic [W-1:0]        cmp_val,
  input  logic [W-1:0]        cap_val,
  input  logic                load,
  input  logic [W-1:0]        load_val,
  output logic [W-1:0]        count,
  output logic                ovf_hit,
  output logic                cmp_hit,
  output logic                top_hit
);
  import tmr16_pkg::*;

  localparam logic [W-1:0] CNT_MAX = '1;

  logic          hush_q;
  logic          step;
  logic          live;
  logic          at_top;
  logic [W-1:0]  top_val;

  assign step    = tick && !load;
  assign live    = step && !hush_q;
  assign top_val = (seq == SEQ_TOP_CAP) ? cap_val : cmp_val;
  assign at_top  = (seq != SEQ_FREE) && (count == top_val);
  assign top_hit = live && at_top;
  assign cmp_hit = live && (count == cmp_val);
  assign ovf_hit = step && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      hush_q <= 1'b0;
    end else begin
      if (load) begin
        count  <= load_val;
        hush_q <= 1'b1;
      end else if (tick) begin
        count  <= top_hit ? '0 : count + 1'b1;
        hush_q <= 1'b0;
      end
    end
  end

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !top_hit && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (count == '0));

  p_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    top_hit |=> (count == '0));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  p_hush_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !cmp_hit && !top_hit);

endmodule

// File: rtl/tmr16_wave.sv
module tmr16_wave (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hit,
  input  logic                  known,
  input  tmr16_pkg::pin_act_e   act,
  output logic                  wave_out,
  output logic                  wave_oe
);
  import tmr16_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_out <= 1'b0;
    end else if (hit && known) begin
      case (act)
        PIN_TOGGLE: wave_out <= ~wave_out;
        PIN_LOW:    wave_out <= 1'b0;
        PIN_HIGH:   wave_out <= 1'b1;
        default:    wave_out <= wave_out;
      endcase
    end
  end

  assign wave_oe = (act != PIN_OFF);

  p_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(wave_out));

  p_pin_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !known |=> $stable(wave_out));

  p_pin_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && known && act == PIN_TOGGLE) |=> (wave_out != $past(wave_out)));

endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= set_vec[i] || (flag[i] && !clr_vec[i]);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag[i]);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag[i]);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr_vec[i]) |=> flag[i]);
  end

endmodule

// File: rtl/tmr16_ctc.sv
module tmr16_ctc #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          ack_ovf,
  input  logic          ack_cmp,
  input  logic          ack_cap,
  output logic [W-1:0]  count,
  output logic          ovf_flag,
  output logic          cmp_flag,
  output logic          cap_flag,
  output logic          wave_out,
  output logic          wave_oe
);
  import tmr16_pkg::*;

  logic [3:0]        seq_code;
  logic [1:0]        pin_code;
  logic [W-1:0]      cmp_val;
  logic [W-1:0]      cap_val;
  logic              cnt_load;
  logic [FLAG_N-1:0] fclr_mask;
  logic              ovf_hit;
  logic              cmp_hit;
  logic              top_hit;
  seq_e              seq;
  logic              known;
  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] clr_vec;
  logic [FLAG_N-1:0] flag_vec;

  assign seq   = seq_of(seq_code);
  assign known = known_code(seq_code);

  tmr16_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .seq_code(seq_code), .pin_act(pin_code), .cmp_val(cmp_val), .cap_val(cap_val),
    .cnt_load(cnt_load), .fclr_mask(fclr_mask)
  );

  tmr16_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seq(seq), .cmp_val(cmp_val),
    .cap_val(cap_val), .load(cnt_load), .load_val(wr_data), .count(count),
    .ovf_hit(ovf_hit), .cmp_hit(cmp_hit), .top_hit(top_hit)
  );

  tmr16_wave u_wave (
    .clk(clk), .rst_n(rst_n), .hit(cmp_hit), .known(known),
    .act(pin_act_e'(pin_code)), .wave_out(wave_out), .wave_oe(wave_oe)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_OVF] = ovf_hit;
    set_vec[FLAG_CMP] = cmp_hit;
    set_vec[FLAG_CAP] = top_hit && (seq == SEQ_TOP_CAP);
    clr_vec           = fclr_mask;
    clr_vec[FLAG_OVF] = clr_vec[FLAG_OVF] | ack_ovf;
    clr_vec[FLAG_CMP] = clr_vec[FLAG_CMP] | ack_cmp;
    clr_vec[FLAG_CAP] = clr_vec[FLAG_CAP] | ack_cap;
  end

  tmr16_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag(flag_vec)
  );

  assign ovf_flag = flag_vec[FLAG_OVF];
  assign cmp_flag = flag_vec[FLAG_CMP];
  assign cap_flag = flag_vec[FLAG_CAP];

  p_no_flag_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (flag_vec & ~$past(flag_vec)) == '0);

  p_ovf_same_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && count == '1) |=> ovf_flag && count == '0);

endmodule

// File: tb/tmr16_ctc_bench.sv
module tmr16_ctc_bench;

  localparam int NV = 8;
  // {seq[82:79], pin[78:77], cmp[76:61], cap[60:45], start[44:29], ticks[28:21],
  //  exp_count[20:5], exp_flags{cap,cmp,ovf}[4:2], exp_pin[1], exp_oe[0]}
  localparam logic [82:0] VEC [NV] = '{
    {4'd0,  2'd0, 16'h1000, 16'h0000, 16'h0000, 8'd5,  16'h0005, 3'b000, 1'b0, 1'b0},
    {4'd0,  2'd1, 16'hFFFE, 16'h0000, 16'hFFFC, 8'd6,  16'h0002, 3'b011, 1'b1, 1'b1},
    {4'd4,  2'd3, 16'h0003, 16'h0000, 16'h0000, 8'd9,  16'h0001, 3'b010, 1'b1, 1'b1},
    {4'd12, 2'd1, 16'h0002, 16'h0004, 16'h0000, 8'd12, 16'h0002, 3'b110, 1'b0, 1'b1},
    {4'd6,  2'd1, 16'h0002, 16'h0000, 16'h0000, 8'd4,  16'h0004, 3'b010, 1'b0, 1'b1},
    {4'd4,  2'd2, 16'h0005, 16'h0000, 16'h0005, 8'd3,  16'h0008, 3'b000, 1'b0, 1'b1},
    {4'd0,  2'd3, 16'hFFFF, 16'h0000, 16'hFFFE, 8'd2,  16'h0000, 3'b011, 1'b1, 1'b1},
    {4'd12, 2'd0, 16'h0100, 16'hFFFF, 16'hFFFD, 8'd3,  16'h0000, 3'b101, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ack_ovf = 1'b0;
  logic        ack_cmp = 1'b0;
  logic        ack_cap = 1'b0;
  logic [15:0] count;
  logic        ovf_flag, cmp_flag, cap_flag, wave_out, wave_oe;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  tmr16_ctc u_tmr16_ctc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .ack_cap(ack_cap),
    .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .cap_flag(cap_flag),
    .wave_out(wave_out), .wave_oe(wave_oe)
  );

  function automatic string vtag(input int i);
    case (i)
      0: vtag = "R2";
      1: vtag = "R3 R7 R8";
      2: vtag = "R5 R7";
      3: vtag = "R6 R7";
      4: vtag = "R9";
      5: vtag = "R8";
      6: vtag = "R3 R7";
      default: vtag = "R6 R3";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctrl(input logic [3:0] sq, input logic [1:0] pa);
    wr(3'd0, {10'd0, pa, sq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 flags", 32'({cap_flag, cmp_flag, ovf_flag}), 32'h0);
    chk("R1 pin", 32'({wave_out, wave_oe}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      ctrl(VEC[i][82:79], VEC[i][78:77]);
      wr(3'd2, VEC[i][76:61]);
      wr(3'd3, VEC[i][60:45]);
      wr(3'd1, VEC[i][44:29]);
      for (int t = 0; t < int'(VEC[i][28:21]); t++) tk();
      chk({vtag(i), " count"}, 32'(count), 32'(VEC[i][20:5]));
      chk({vtag(i), " flags"}, 32'({cap_flag, cmp_flag, ovf_flag}), 32'(VEC[i][4:2]));
      chk({vtag(i), " pin"}, 32'(wave_out), 32'(VEC[i][1]));
      chk({vtag(i), " oe"}, 32'(wave_oe), 32'(VEC[i][0]));
    end

    // R10: no tick, nothing moves
    do_reset();
    wr(3'd1, 16'h000A);
    repeat (5) @(negedge clk);
    chk("R10 hold count", 32'(count), 32'h000A);
    chk("R10 no flags", 32'({cap_flag, cmp_flag, ovf_flag}), 32'h0);

    // R8: count write beats a same-cycle tick
    tick = 1'b1;
    wr(3'd1, 16'h0200);
    tick = 1'b0;
    chk("R8 write over tick", 32'(count), 32'h0200);

    // R4: ack clear, same-cycle set wins, write-1 clear
    wr(3'd1, 16'hFFFF);
    tk();
    chk("R3 ovf set", 32'(ovf_flag), 32'h1);
    ack_ovf = 1'b1; @(negedge clk); ack_ovf = 1'b0;
    chk("R4 ack clears", 32'(ovf_flag), 32'h0);
    wr(3'd1, 16'hFFFF);
    tick = 1'b1; ack_ovf = 1'b1;
    @(negedge clk);
    tick = 1'b0; ack_ovf = 1'b0;
    chk("R4 set wins", 32'(ovf_flag), 32'h1);
    wr(3'd4, 16'h0001);
    chk("R4 write-1 clear", 32'(ovf_flag), 32'h0);

    // R7: set then clear action, then released pin
    do_reset();
    ctrl(4'd4, 2'd3);
    wr(3'd2, 16'h0001);
    tk(); tk();
    chk("R7 set action", 32'(wave_out), 32'h1);
    chk("R5 wrap at top", 32'(count), 32'h0);
    ctrl(4'd4, 2'd2);
    tk(); tk();
    chk("R7 clear action", 32'(wave_out), 32'h0);
    ctrl(4'd4, 2'd0);
    chk("R7 released oe", 32'(wave_oe), 32'h0);
    ack_cmp = 1'b1; @(negedge clk); ack_cmp = 1'b0;
    chk("R4 ack_cmp", 32'(cmp_flag), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule